// File: doc/BRIEF.md
# Serial Non-Volatile RAM Target

This block is a synthesizable model of a small serial memory device that has two arrays: a volatile working array of 16 words of 16 bits, and a shadow array of the same size that stands in for the non-volatile cells. A host selects the device by raising chip enable. It then clocks in an instruction byte, most significant bit first, on a serial clock and a serial data line. Single-word reads and writes go to the working array. Whole-array transfers go between the two arrays: recall copies shadow to working, and store copies working to shadow.

Two status latches gate the commands that change contents. A write-enable latch must be set before a word write takes effect. A store also needs a recall latch, which only a recall sets. The serial pins are oversampled in the system clock domain through a synchronizer and an edge detector. A test port shows any word of either array combinationally, and shows the three status flags.

Top module: `novram_serial`

## Requirements
- R1: While reset is asserted and after its release, every word of both arrays reads zero, the write-enable, recall and low-power flags are clear, and `sdo_oe` is low.
- R2: Instruction bytes are taken MSB first, one bit per rising serial clock edge. A byte with bit 7 set and bits 2:0 equal to 100 sets the write-enable latch, and one with bits 2:0 equal to 000 clears it. Bits 6:3 are don't-care for these two commands, so 0x84 and 0xFC both enable.
- R3: Write is 1aaaa011, with the word address aaaa in bits 6:3, followed by 16 data bits MSB first. When the write-enable latch is set, the addressed working word takes the data on the 16th data rising edge.
- R4: A write issued while the write-enable latch is clear leaves the working array unchanged.
- R5: Read is recognised after the 7 bits 1aaaa11. The 8th rising clock is turnaround and `sdo_oe` stays low through it. After the 8th falling edge the device drives bit 15 of the addressed word, and each later falling edge presents the next lower bit. `sdo_oe` drops after the falling edge that follows the 16th data bit.
- R6: Recall (bits 2:0 = 101) copies every shadow word into the working array, sets the recall latch, clears the write-enable latch and clears the low-power flag.
- R7: Store (bits 2:0 = 001) copies the working array into the shadow array only when both the write-enable latch and the recall latch are set. Otherwise the shadow array is unchanged.
- R8: Sleep (bits 2:0 = 010) sets the low-power flag. Only a recall clears it.
- R9: Lowering chip enable aborts any partial instruction. A write cut short changes no memory, and the next selection decodes from its first bit.
- R10: `sdo_oe` is low whenever chip enable is low and outside the read data phase.
- R11: A byte with bit 7 clear is ignored: no latch, flag or array changes.
- R12: Data is sampled on the rising serial clock edge. A change of `sdi` while the serial clock is high does not alter the bit taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Chip enable, active high |
| sk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data, held low when not enabled |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| wel | output | 1 | Write-enable latch state |
| rcl | output | 1 | Recall latch state |
| sleep | output | 1 | Low-power flag |
| dbg_nv | input | 1 | Test port select: 1 shows the shadow array, 0 the working array |
| dbg_addr | input | 4 | Test port word address |
| dbg_word | output | 16 | Test port word value |

## Verification
A change on `ce`, `sk` or `sdi` passes two synchronizer flops and an edge register, and the controller acts on the third rising system clock edge after it. A latch, array word or `sdo`/`sdo_oe` value is therefore settled four system clocks after the serial edge that caused it. The bench holds every serial clock phase for eight system clocks and samples only at the end of a phase, on a falling system clock edge. Read bits are taken just before the next rising serial edge, and the turnaround check on `sdo_oe` is made late in the 8th high phase.

// File: rtl/novram_pkg.sv
package novram_pkg;

  // Word address field width, fixed by the instruction layout (bits 6:3)
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  // Command code held in instruction bits 2:0 (bit 7 must be set)
  localparam logic [2:0] CMD_WRDIS = 3'b000;
  localparam logic [2:0] CMD_STORE = 3'b001;
  localparam logic [2:0] CMD_SLEEP = 3'b010;
  localparam logic [2:0] CMD_WRITE = 3'b011;
  localparam logic [2:0] CMD_WREN  = 3'b100;
  localparam logic [2:0] CMD_RECAL = 3'b101;

  typedef enum logic [1:0] {
    ST_OPCODE = 2'd0,
    ST_WDATA  = 2'd1,
    ST_RDATA  = 2'd2,
    ST_HOLD   = 2'd3
  } ser_state_t;

endpackage

// File: rtl/novram_pin_sync.sv
module novram_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sk,
  input  logic sdi,
  output logic rst_sync,
  output logic ce_s,
  output logic di_s,
  output logic sk_rise,
  output logic sk_fall
);

  localparam int PIN_W = 3;

  logic [1:0]       rst_pipe;
  logic [PIN_W-1:0] pipe [STAGES];
  logic             sk_last;
  logic             sk_now;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  for (genvar g = 0; g < STAGES; g++) begin : gen_stage
    if (g == 0) begin : gen_first
      always_ff @(posedge clk or negedge rst_sync) begin
        if (!rst_sync) pipe[g] <= '0;
        else           pipe[g] <= {ce, sk, sdi};
      end
    end else begin : gen_next
      always_ff @(posedge clk or negedge rst_sync) begin
        if (!rst_sync) pipe[g] <= '0;
        else           pipe[g] <= pipe[g-1];
      end
    end
  end

  assign ce_s   = pipe[STAGES-1][2];
  assign sk_now = pipe[STAGES-1][1];
  assign di_s   = pipe[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) sk_last <= 1'b0;
    else           sk_last <= sk_now;
  end

  assign sk_rise = sk_now & ~sk_last;
  assign sk_fall = ~sk_now & sk_last;

endmodule

// File: rtl/novram_arrays.sv
module novram_arrays
  import novram_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    recall,
  input  logic                    store,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [WORD_W-1:0]       rd_data,
  output logic [DEPTH*WORD_W-1:0] ram_flat,
  output logic [DEPTH*WORD_W-1:0] nv_flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : gen_word
    logic [WORD_W-1:0] ram_q, ram_d;
    logic [WORD_W-1:0] nv_q, nv_d;
    logic              ram_en, nv_en;

    always_comb begin
      ram_en = recall | (wr_en & (wr_addr == ADDR_W'(g)));
      ram_d  = recall ? nv_q : wr_data;
      nv_en  = store;
      nv_d   = ram_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ram_q <= '0;
      else if (ram_en) ram_q <= ram_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     nv_q <= '0;
      else if (nv_en) nv_q <= nv_d;
    end

    assign ram_flat[g*WORD_W +: WORD_W] = ram_q;
    assign nv_flat[g*WORD_W +: WORD_W]  = nv_q;
  end

  assign rd_data = ram_flat[rd_addr*WORD_W +: WORD_W];

endmodule

// File: rtl/novram_ctrl.sv
module novram_ctrl
  import novram_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              di_s,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              do_recall,
  output logic              do_store,
  output logic              wel,
  output logic              rcl,
  output logic              sleep,
  output logic              sdo_bit,
  output logic              sdo_oe
);

  localparam int OP_W  = 8;
  localparam int CNT_W = $clog2(WORD_W + 1) + 1;

  ser_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [OP_W-1:0]   op_q, op_d, op_shift;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] wsh_q, wsh_d, wsh_shift;
  logic [WORD_W-1:0] rsh_q, rsh_d;
  logic              pend_q, pend_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;
  logic              wel_q, wel_d;
  logic              rcl_q, rcl_d;
  logic              slp_q, slp_d;

  assign op_shift  = {op_q[OP_W-2:0], di_s};
  assign wsh_shift = {wsh_q[WORD_W-2:0], di_s};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    op_d      = op_q;
    addr_d    = addr_q;
    wsh_d     = wsh_q;
    rsh_d     = rsh_q;
    pend_d    = pend_q;
    sdo_d     = sdo_q;
    oe_d      = oe_q;
    wel_d     = wel_q;
    rcl_d     = rcl_q;
    slp_d     = slp_q;
    mem_we    = 1'b0;
    do_recall = 1'b0;
    do_store  = 1'b0;

    if (!ce_s) begin
      state_d = ST_OPCODE;
      cnt_d   = '0;
      idx_d   = '0;
      pend_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_OPCODE: begin
          if (sk_rise) begin
            op_d  = op_shift;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(OP_W - 2) && op_shift[OP_W-2] && (op_shift[1:0] == 2'b11)) begin
              // seven bits 1aaaa11: read, next clock is turnaround
              addr_d  = op_shift[OP_W-3:2];
              idx_d   = '0;
              state_d = ST_RDATA;
            end else if (cnt_q == CNT_W'(OP_W - 1)) begin
              state_d = ST_HOLD;
              if (op_shift[OP_W-1]) begin
                case (op_shift[2:0])
                  CMD_WRITE: begin
                    addr_d  = op_shift[OP_W-2:3];
                    cnt_d   = '0;
                    state_d = ST_WDATA;
                  end
                  CMD_WREN:  wel_d = 1'b1;
                  CMD_WRDIS: wel_d = 1'b0;
                  CMD_RECAL: begin
                    do_recall = 1'b1;
                    rcl_d     = 1'b1;
                    wel_d     = 1'b0;
                    slp_d     = 1'b0;
                  end
                  CMD_STORE: do_store = wel_q & rcl_q;
                  CMD_SLEEP: slp_d = 1'b1;
                  default:   ;
                endcase
              end
            end
          end
        end

        ST_WDATA: begin
          if (sk_rise) begin
            wsh_d = wsh_shift;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(WORD_W - 1)) begin
              mem_we  = wel_q;
              state_d = ST_HOLD;
            end
          end
        end

        ST_RDATA: begin
          if (sk_rise) begin
            pend_d = 1'b1;
            if (idx_q == '0) rsh_d = rd_word;
          end else if (sk_fall && pend_q) begin
            pend_d = 1'b0;
            if (idx_q < CNT_W'(WORD_W)) begin
              sdo_d = rsh_q[WORD_W-1];
              rsh_d = {rsh_q[WORD_W-2:0], 1'b0};
              oe_d  = 1'b1;
              idx_d = idx_q + 1'b1;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_HOLD;
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPCODE;
      cnt_q   <= '0;
      idx_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wsh_q   <= '0;
      rsh_q   <= '0;
      pend_q  <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      wel_q   <= 1'b0;
      rcl_q   <= 1'b0;
      slp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      wsh_q   <= wsh_d;
      rsh_q   <= rsh_d;
      pend_q  <= pend_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
      wel_q   <= wel_d;
      rcl_q   <= rcl_d;
      slp_q   <= slp_d;
    end
  end

  assign addr      = addr_q;
  assign mem_wdata = wsh_shift;
  assign wel       = wel_q;
  assign rcl       = rcl_q;
  assign sleep     = slp_q;
  assign sdo_bit   = sdo_q;
  assign sdo_oe    = oe_q;

endmodule

// File: rtl/novram_serial.sv
module novram_serial
  import novram_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wel,
  output logic              rcl,
  output logic              sleep,
  input  logic              dbg_nv,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [WORD_W-1:0] dbg_word
);

  logic                    rst_sync;
  logic                    ce_s, di_s, sk_rise, sk_fall;
  logic [ADDR_W-1:0]       addr;
  logic                    mem_we, do_recall, do_store;
  logic [WORD_W-1:0]       mem_wdata, rd_word;
  logic [DEPTH*WORD_W-1:0] ram_flat, nv_flat;
  logic                    sdo_bit;

  novram_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .sk       (sk),
    .sdi      (sdi),
    .rst_sync (rst_sync),
    .ce_s     (ce_s),
    .di_s     (di_s),
    .sk_rise  (sk_rise),
    .sk_fall  (sk_fall)
  );

  novram_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ce_s      (ce_s),
    .di_s      (di_s),
    .sk_rise   (sk_rise),
    .sk_fall   (sk_fall),
    .rd_word   (rd_word),
    .addr      (addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .do_recall (do_recall),
    .do_store  (do_store),
    .wel       (wel),
    .rcl       (rcl),
    .sleep     (sleep),
    .sdo_bit   (sdo_bit),
    .sdo_oe    (sdo_oe)
  );

  novram_arrays #(.WORD_W(WORD_W)) u_mem (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_en    (mem_we),
    .wr_addr  (addr),
    .wr_data  (mem_wdata),
    .recall   (do_recall),
    .store    (do_store),
    .rd_addr  (addr),
    .rd_data  (rd_word),
    .ram_flat (ram_flat),
    .nv_flat  (nv_flat)
  );

  assign sdo      = sdo_oe & sdo_bit;
  assign dbg_word = dbg_nv ? nv_flat[dbg_addr*WORD_W +: WORD_W]
                           : ram_flat[dbg_addr*WORD_W +: WORD_W];

endmodule

// File: rtl/novram_chk.sv
module novram_chk #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce_s,
  input logic                    sk_fall,
  input logic                    sdo_oe,
  input logic                    wel,
  input logic                    rcl,
  input logic                    sleep,
  input logic                    mem_we,
  input logic                    do_recall,
  input logic                    do_store,
  input logic [DEPTH*WORD_W-1:0] ram_flat,
  input logic [DEPTH*WORD_W-1:0] nv_flat
);

  assert_oe_off_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdo_oe);

  assert_oe_starts_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sk_fall));

  assert_recall_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_recall |=> (ram_flat == $past(nv_flat)) && !wel && rcl && !sleep);

  assert_ram_change_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_flat != $past(ram_flat)) |-> $past(do_recall || (mem_we && wel)));

  assert_nv_change_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_flat != $past(nv_flat)) |-> $past(do_store && wel && rcl));

  assert_sleep_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> $past(do_recall));

endmodule

bind novram_serial novram_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync),
  .ce_s      (ce_s),
  .sk_fall   (sk_fall),
  .sdo_oe    (sdo_oe),
  .wel       (wel),
  .rcl       (rcl),
  .sleep     (sleep),
  .mem_we    (mem_we),
  .do_recall (do_recall),
  .do_store  (do_store),
  .ram_flat  (ram_flat),
  .nv_flat   (nv_flat)
);

// File: tb/tb_novram_serial.sv
`timescale 1ns/1ps
module tb_novram_serial;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, ce, sk, sdi, dbg_nv;
  logic [3:0]  dbg_addr;
  logic        sdo, sdo_oe, wel, rcl, sleep;
  logic [15:0] dbg_word;
  int          checks = 0;
  int          fails  = 0;
  bit          wiggle = 1'b0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  novram_serial dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wel(wel), .rcl(rcl), .sleep(sleep),
    .dbg_nv(dbg_nv), .dbg_addr(dbg_addr), .dbg_word(dbg_word)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] peek(input logic nv, input logic [3:0] a);
    dbg_nv   = nv;
    dbg_addr = a;
    return 16'h0;
  endfunction

  task automatic look(input logic nv, input logic [3:0] a, output logic [15:0] w);
    dbg_nv = nv; dbg_addr = a; #1; w = dbg_word;
  endtask

  task automatic sbit(input logic b);
    sdi = b; wt(HALF); sk = 1'b1;
    if (wiggle) begin wt(HALF/2); sdi = ~b; wt(HALF - HALF/2); end
    else wt(HALF);
    sk = 1'b0;
  endtask

  task automatic select();
    ce = 1'b1; wt(HALF);
  endtask

  task automatic deselect();
    wt(HALF); ce = 1'b0; sdi = 1'b0; wt(HALF);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cmd(input logic [7:0] op);
    select(); send_bits({8'h0, op}, 8); deselect();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    select(); send_bits({8'h0, 1'b1, a, 3'b011}, 8); send_bits(d, 16); deselect();
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] w);
    logic oe_all;
    select();
    send_bits({9'h0, 1'b1, a, 2'b11}, 7);
    sdi = 1'b0; wt(HALF); sk = 1'b1; wt(HALF);
    chk("R5 oe low in turnaround", {31'h0, sdo_oe}, 32'h0);
    sk = 1'b0; wt(HALF);
    oe_all = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      w[i] = sdo;
      oe_all = oe_all & sdo_oe;
      if (i > 0) begin sk = 1'b1; wt(HALF); sk = 1'b0; wt(HALF); end
    end
    chk("R5 oe high during data", {31'h0, oe_all}, 32'h1);
    sk = 1'b1; wt(HALF); sk = 1'b0; wt(HALF);
    chk("R5 oe released after last bit", {31'h0, sdo_oe}, 32'h0);
    deselect();
  endtask

  task automatic t_reset();
    logic [15:0] w;
    logic        any;
    any = 1'b0;
    for (int a = 0; a < 16; a++) begin
      look(1'b0, 4'(a), w); any = any | (|w);
      look(1'b1, 4'(a), w); any = any | (|w);
    end
    chk("R1 arrays zero", {31'h0, any}, 32'h0);
    chk("R1 flags clear", {29'h0, wel, rcl, sleep}, 32'h0);
    chk("R1 oe low", {31'h0, sdo_oe}, 32'h0);
  endtask

  task automatic t_locked_write();
    logic [15:0] w;
    wr(4'd3, 16'h1234);
    look(1'b0, 4'd3, w);
    chk("R4 write without enable", {16'h0, w}, 32'h0);
  endtask

  task automatic t_latch();
    cmd(8'h84); chk("R2 enable sets latch", {31'h0, wel}, 32'h1);
    cmd(8'h04); chk("R11 bit7 clear ignored", {31'h0, wel}, 32'h1);
    cmd(8'h00); chk("R11 bit7 clear ignored (disable code)", {31'h0, wel}, 32'h1);
    cmd(8'h80); chk("R2 disable clears latch", {31'h0, wel}, 32'h0);
    cmd(8'hFC); chk("R2 address bits don't care", {31'h0, wel}, 32'h1);
    cmd(8'h80);
  endtask

  task automatic t_store();
    logic [15:0] w;
    cmd(8'h84); wr(4'd2, 16'hBEEF); cmd(8'h81);
    look(1'b1, 4'd2, w);
    chk("R7 store blocked without recall latch", {16'h0, w}, 32'h0);
    cmd(8'h85);
    look(1'b0, 4'd2, w);
    chk("R6 recall overwrites working word", {16'h0, w}, 32'h0);
    chk("R6 recall latch set, enable cleared", {30'h0, rcl, wel}, 32'h2);
    cmd(8'h84); wr(4'd2, 16'hBEEF); cmd(8'h80); cmd(8'h81);
    look(1'b1, 4'd2, w);
    chk("R7 store blocked without enable", {16'h0, w}, 32'h0);
    cmd(8'h84); cmd(8'h81);
    look(1'b1, 4'd2, w);
    chk("R7 store copies word", {16'h0, w}, 32'h0000BEEF);
  endtask

  task automatic t_rw();
    logic [15:0] w;
    cmd(8'h84);
    wr(4'd0, 16'h8001);
    wiggle = 1'b1; wr(4'd15, 16'hA5C3); wiggle = 1'b0;
    look(1'b0, 4'd0, w);
    chk("R3 write word 0", {16'h0, w}, 32'h00008001);
    look(1'b0, 4'd15, w);
    chk("R12 bits taken at rising edge", {16'h0, w}, 32'h0000A5C3);
    rd(4'd15, w); chk("R5 serial read word 15", {16'h0, w}, 32'h0000A5C3);
    rd(4'd0, w);  chk("R5 serial read word 0", {16'h0, w}, 32'h00008001);
    rd(4'd2, w);  chk("R3 serial read word 2", {16'h0, w}, 32'h0000BEEF);
  endtask

  task automatic t_sleep_recall();
    logic [15:0] w;
    cmd(8'h82);
    chk("R8 sleep sets flag", {31'h0, sleep}, 32'h1);
    cmd(8'h84); cmd(8'h80);
    chk("R8 flag kept by other commands", {31'h0, sleep}, 32'h1);
    cmd(8'h84); wr(4'd2, 16'h0F0F);
    cmd(8'h85);
    look(1'b0, 4'd2, w);
    chk("R6 recall restores word", {16'h0, w}, 32'h0000BEEF);
    look(1'b0, 4'd15, w);
    chk("R6 recall copies unstored word", {16'h0, w}, 32'h0);
    chk("R6 recall clears sleep and enable", {30'h0, sleep, wel}, 32'h0);
  endtask

  task automatic t_abort();
    logic [15:0] w;
    cmd(8'h84);
    select(); send_bits({8'h0, 8'hBB}, 8); send_bits(16'h00FF, 8);
    ce = 1'b0; sdi = 1'b0; wt(HALF);
    look(1'b0, 4'd7, w);
    chk("R9 partial write no update", {16'h0, w}, 32'h0);
    select(); send_bits(16'h7, 3); ce = 1'b0; sdi = 1'b0; wt(HALF);
    cmd(8'h80);
    chk("R9 decode restarts after abort", {31'h0, wel}, 32'h0);
    select(); send_bits({9'h0, 7'h7B}, 7);
    sdi = 1'b0; wt(HALF); sk = 1'b1; wt(HALF); sk = 1'b0; wt(HALF);
    sk = 1'b1; wt(HALF); sk = 1'b0; wt(HALF);
    chk("R5 oe on mid read", {31'h0, sdo_oe}, 32'h1);
    ce = 1'b0; wt(HALF);
    chk("R10 oe off when deselected", {31'h0, sdo_oe}, 32'h0);
    sk = 1'b1; wt(HALF); sk = 1'b0; wt(HALF);
    chk("R10 oe stays off while ce low", {31'h0, sdo_oe}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; sk = 1'b0; sdi = 1'b0; dbg_nv = 1'b0; dbg_addr = '0;
    wt(5);
    t_reset();
    rst_n = 1'b1;
    wt(6);
    t_reset();
    t_locked_write();
    t_latch();
    t_store();
    t_rw();
    t_sleep_recall();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule